// File: doc/BRIEF.md
# T1 Framing Bit Error Monitor

The block sits behind a T1 receive framer that has already found alignment. For every received bit it gets a valid strobe, and for the framing bit that opens each 193-bit frame it also gets a separate strobe. The framer also supplies the frame's position in the multiframe, the active format (12-frame superframe or 24-frame extended superframe) and a flag that shows the framer is locked. From these inputs the block checks the framing bits against the expected patterns. It raises a severe-error event when errors bunch inside fixed windows. In extended superframe mode it runs the CRC-6 check.

Results are held as sticky status bits. A small register port reads them and clears them by writing 1. The same port sets an enable mask. One interrupt output is the OR of every status bit that is both set and enabled. While the framer is unlocked the block raises no events, and it restarts its window counters and its CRC history.

Top module: `t1fm_monitor`

## Requirements
- R1: In superframe mode (fmt_esf=0) the framing bit of each odd frame 1,3,5,7,9,11 must equal 1,0,1,0,1,0 in turn. A mismatch sets status bit 1. Framing bits of even frames are not checked.
- R2: In superframe mode, status bit 2 is set by the second and any later frame-bit error inside one fixed window. The windows are frames 1-6 and frames 7-12. Errors in different windows never combine.
- R3: In extended mode (fmt_esf=1) the framing bits of frames 4,8,12,16,20,24 must equal 0,0,1,0,1,1. A mismatch sets status bit 1. Framing bits of all other frames are not checked for alignment.
- R4: In extended mode, status bit 2 is set by the second and any later alignment error inside one multiframe. The window restarts at frame 1.
- R5: In extended mode a CRC-6 with generator x^6+x+1 is computed over every bit of a multiframe, starting from zero, with framing-bit positions counted as 1. It is compared with the six bits carried in frames 2,6,...,22 of the next multiframe, first bit most significant. A mismatch, judged on the frame-22 framing bit, sets status bit 3.
- R6: No CRC comparison is made until a complete multiframe has been computed while locked. A CRC error therefore cannot occur in the first multiframe, or the partial multiframe, after lock is gained.
- R7: Status bit 0 is set on the framing bit of frame 1 only while in_sync=1.
- R8: While in_sync=0 no status bit is set, and the severe-error window count restarts from zero.
- R9: Register address 0 reads the status in bits [3:0], with zeros above. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Address 1 reads and writes the enable mask in bits [3:0]. Other addresses read 0.
- R10: A new event wins over a clear of the same bit in the same cycle.
- R11: irq is 1 exactly when some status bit and its mask bit are both 1.
- R12: After reset the status, the mask and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_data | input | 1 | Received bit value |
| fbit_stb | input | 1 | The present bit is the framing bit of its frame |
| frame_num | input | 5 | Frame position in the multiframe, 1-based |
| fmt_esf | input | 1 | 0 selects superframe, 1 selects extended superframe |
| in_sync | input | 1 | Framer locked |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq | output | 1 | Combined interrupt |

## Verification
Every event is decided from the inputs sampled at one rising edge. The status bit it sets, and irq with it, therefore change at that same edge and are visible from then on. A register write likewise takes effect at the edge that samples it, while read data follows the address with no delay. The bench drives each cycle's inputs after a falling edge and advances its behavioural model by one step for that edge. It compares the read data and irq at the next falling edge, so model and design always describe the same edge.

// File: rtl/t1fm_pkg.sv
package t1fm_pkg;
  localparam int unsigned ST_W    = 4;
  localparam int unsigned ST_MFB  = 0;
  localparam int unsigned ST_FERR = 1;
  localparam int unsigned ST_SEV  = 2;
  localparam int unsigned ST_CRC  = 3;
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_MASK   = 1;
endpackage

// File: rtl/t1fm_fbit_check.sv
module t1fm_fbit_check #(
  parameter int unsigned FN_W    = 5,
  parameter int unsigned SF_WIN  = 6,
  parameter int unsigned SEV_THR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_vld,
  input  logic            bit_data,
  input  logic            fbit_stb,
  input  logic [FN_W-1:0] fnum,
  input  logic            fmt_esf,
  input  logic            in_sync,
  output logic            mfb_ev,
  output logic            ferr_ev,
  output logic            sev_ev
);
  localparam int unsigned CNT_W = $clog2(SEV_THR + 1);

  function automatic logic sf_expect(input logic [FN_W-1:0] fn);
    return (fn[1:0] == 2'b01);
  endfunction

  function automatic logic esf_expect(input logic [FN_W-1:0] fn);
    logic [FN_W-3:0] idx;
    idx = fn[FN_W-1:2];
    return (idx == (FN_W-2)'(3)) || (idx == (FN_W-2)'(5)) || (idx == (FN_W-2)'(6));
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             cnt_en;
  logic             fpos, chk_pos, exp_bit, win_start, err;

  always_comb begin
    fpos = bit_vld & fbit_stb & in_sync;
    if (fmt_esf) begin
      chk_pos   = (fnum[1:0] == 2'b00) && (fnum != '0);
      exp_bit   = esf_expect(fnum);
      win_start = (fnum == FN_W'(1));
    end else begin
      chk_pos   = fnum[0];
      exp_bit   = sf_expect(fnum);
      win_start = ((fnum % FN_W'(SF_WIN)) == FN_W'(1));
    end
    err      = fpos & chk_pos & (bit_data != exp_bit);
    cnt_base = (fpos & win_start) ? '0 : cnt_q;
    ferr_ev  = err;
    sev_ev   = err & (cnt_base >= CNT_W'(SEV_THR - 1));
    mfb_ev   = fpos & (fnum == FN_W'(1));
  end

  always_comb begin
    cnt_en = ~in_sync | fpos;
    cnt_d  = cnt_q;
    if (!in_sync) begin
      cnt_d = '0;
    end else if (fpos) begin
      cnt_d = cnt_base;
      if (err && (cnt_base != CNT_W'(SEV_THR)))
        cnt_d = cnt_base + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/t1fm_crc6.sv
module t1fm_crc6 #(
  parameter int unsigned FN_W     = 5,
  parameter int unsigned CRC_W    = 6,
  parameter logic [CRC_W-1:0] CRC_POLY = 6'b000011,
  parameter int unsigned LAST_C   = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_vld,
  input  logic            bit_data,
  input  logic            fbit_stb,
  input  logic [FN_W-1:0] fnum,
  input  logic            fmt_esf,
  input  logic            in_sync,
  output logic            crc_ev
);
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] s, input logic d);
    logic fb;
    fb = s[CRC_W-1] ^ d;
    return {s[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  logic [CRC_W-1:0] lfsr_q, lfsr_d, ref_q, rx_q, rx_word;
  logic             run_q, run_d, refv_q, refv_d;
  logic             active, bvld, fpos, mf_start, din, cpos;
  logic             lfsr_en, ref_en, rx_en;

  always_comb begin
    active   = in_sync & fmt_esf;
    bvld     = bit_vld & active;
    fpos     = bvld & fbit_stb;
    mf_start = fpos & (fnum == FN_W'(1));
    din      = fbit_stb | bit_data;
    cpos     = fpos & (fnum[1:0] == 2'b10);
    rx_word  = {rx_q[CRC_W-2:0], bit_data};
    crc_ev   = cpos & (fnum == FN_W'(LAST_C)) & refv_q & (rx_word != ref_q);
  end

  always_comb begin
    lfsr_en = ~active | bvld;
    lfsr_d  = lfsr_q;
    run_d   = run_q;
    refv_d  = refv_q;
    ref_en  = 1'b0;
    rx_en   = cpos;
    if (!active) begin
      lfsr_d = '0;
      run_d  = 1'b0;
      refv_d = 1'b0;
    end else if (mf_start) begin
      lfsr_d = crc_step('0, din);
      run_d  = 1'b1;
      ref_en = run_q;
      if (run_q) refv_d = 1'b1;
    end else if (bvld) begin
      lfsr_d = crc_step(lfsr_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '0;
      run_q  <= 1'b0;
      refv_q <= 1'b0;
    end else begin
      if (lfsr_en) lfsr_q <= lfsr_d;
      run_q  <= run_d;
      refv_q <= refv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      rx_q  <= '0;
    end else begin
      if (ref_en) ref_q <= lfsr_q;
      if (rx_en)  rx_q  <= rx_word;
    end
  end
endmodule

// File: rtl/t1fm_status_regs.sv
module t1fm_status_regs
  import t1fm_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ST_W-1:0]   ev,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ST_W-1:0]   status_q,
  output logic              irq
);
  logic            wr_st, wr_mk;
  logic [ST_W-1:0] clr, st_d, st_en, mask_q;

  always_comb begin
    wr_st = reg_wr & (reg_addr == ADDR_W'(ADDR_STATUS));
    wr_mk = reg_wr & (reg_addr == ADDR_W'(ADDR_MASK));
    clr   = wr_st ? reg_wdata[ST_W-1:0] : '0;
    st_d  = ev | (status_q & ~clr);
    st_en = ev | clr;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_st
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (st_en[i]) bit_q <= st_d[i];
    end
    assign status_q[i] = bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_mk) mask_q <= reg_wdata[ST_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_STATUS))
      reg_rdata = {{(DATA_W-ST_W){1'b0}}, status_q};
    else if (reg_addr == ADDR_W'(ADDR_MASK))
      reg_rdata = {{(DATA_W-ST_W){1'b0}}, mask_q};
    irq = |(status_q & mask_q);
  end
endmodule

// File: rtl/t1fm_monitor.sv
module t1fm_monitor
  import t1fm_pkg::*;
#(
  parameter int unsigned FN_W    = 5,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SF_WIN  = 6,
  parameter int unsigned SEV_THR = 2,
  parameter int unsigned ESF_LEN = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_data,
  input  logic              fbit_stb,
  input  logic [FN_W-1:0]   frame_num,
  input  logic              fmt_esf,
  input  logic              in_sync,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned LAST_C = ESF_LEN - 2;

  logic [ST_W-1:0] ev, status_q;
  logic            mfb_ev, ferr_ev, sev_ev, crc_ev;

  t1fm_fbit_check #(.FN_W(FN_W), .SF_WIN(SF_WIN), .SEV_THR(SEV_THR)) u_fbit (
    .clk, .rst_n, .bit_vld, .bit_data, .fbit_stb, .fnum(frame_num),
    .fmt_esf, .in_sync, .mfb_ev, .ferr_ev, .sev_ev
  );

  t1fm_crc6 #(.FN_W(FN_W), .LAST_C(LAST_C)) u_crc (
    .clk, .rst_n, .bit_vld, .bit_data, .fbit_stb, .fnum(frame_num),
    .fmt_esf, .in_sync, .crc_ev
  );

  always_comb begin
    ev          = '0;
    ev[ST_MFB]  = mfb_ev;
    ev[ST_FERR] = ferr_ev;
    ev[ST_SEV]  = sev_ev;
    ev[ST_CRC]  = crc_ev;
  end

  t1fm_status_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk, .rst_n, .ev, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata, .status_q, .irq
  );
endmodule

// File: rtl/t1fm_monitor_chk.sv
module t1fm_monitor_chk #(
  parameter int unsigned FN_W   = 5,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LAST_C = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_vld,
  input logic              bit_data,
  input logic              fbit_stb,
  input logic [FN_W-1:0]   frame_num,
  input logic              fmt_esf,
  input logic              in_sync,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [3:0]        status_q,
  input logic              irq
);
  logic [3:0] clr_bits;
  logic       sf_ft_bad;

  always_comb begin
    clr_bits  = (reg_wr && reg_addr == '0) ? reg_wdata[3:0] : 4'b0;
    sf_ft_bad = bit_vld && fbit_stb && in_sync && !fmt_esf && frame_num[0] &&
                (bit_data != (frame_num[1:0] == 2'b01));
  end

  // R9: a set bit stays set unless written with 1
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_bits)) == $past(status_q & ~clr_bits)));

  a_r7_mfb_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[0]) |-> $past(bit_vld && fbit_stb && in_sync && frame_num == FN_W'(1)));

  a_r8_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> ((status_q & ~$past(status_q)) == 4'b0));

  a_r2_severe_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[2]) |-> status_q[1]);

  a_r5_crc_position: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[3]) |-> $past(fmt_esf && in_sync && bit_vld && fbit_stb &&
                                 frame_num == FN_W'(LAST_C)));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_ft_bad && clr_bits[1]) |=> status_q[1]);

  a_r11_idle_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 4'b0) |-> !irq);
endmodule

bind t1fm_monitor t1fm_monitor_chk #(
  .FN_W(FN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAST_C(LAST_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_data(bit_data),
  .fbit_stb(fbit_stb), .frame_num(frame_num), .fmt_esf(fmt_esf),
  .in_sync(in_sync), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .status_q(status_q), .irq(irq)
);

// File: tb/tb_t1fm_monitor.sv
module tb_t1fm_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n, bit_vld, bit_data, fbit_stb, fmt_esf, in_sync, reg_wr;
  logic [4:0] frame_num;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq;

  t1fm_monitor dut (
    .clk, .rst_n, .bit_vld, .bit_data, .fbit_stb, .frame_num, .fmt_esf,
    .in_sync, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  int unsigned lcg    = 32'h1234_5678;
  string       tag    = "";

  // behavioural reference state
  logic [3:0] m_st = 4'h0, m_mask = 4'h0;
  int         m_cnt = 0;
  bit         m_run = 1'b0, m_refv = 1'b0;
  logic [5:0] m_ref = 6'h0, m_rx = 6'h0;
  bit         m_q[$];

  function automatic bit rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  function automatic logic [5:0] crc_of_queue();
    bit w[$];
    int n;
    logic [5:0] r;
    w = m_q;
    n = m_q.size();
    repeat (6) w.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      if (w[i]) begin
        w[i]   = 1'b0;
        w[i+5] = ~w[i+5];
        w[i+6] = ~w[i+6];
      end
    end
    for (int k = 0; k < 6; k++) r[5-k] = w[n+k];
    return r;
  endfunction

  task automatic model_step(input bit vld, input bit isf, input bit d, input int fn,
                            input bit esf, input bit sync, input bit wr,
                            input logic [1:0] a, input logic [7:0] wd);
    logic [3:0] ev;
    bit chk, expv, ws, e;
    ev = 4'h0;
    if (!sync) begin
      m_cnt = 0; m_run = 1'b0; m_refv = 1'b0; m_q.delete();
    end else if (vld) begin
      if (isf && fn == 1) ev[0] = 1'b1;
      if (isf) begin
        if (esf) begin
          chk = (fn % 4 == 0); expv = (fn == 12 || fn == 20 || fn == 24); ws = (fn == 1);
        end else begin
          chk = (fn % 2 == 1); expv = (fn % 4 == 1); ws = (fn == 1 || fn == 7);
        end
        if (ws) m_cnt = 0;
        e = chk && (d != expv);
        if (e) begin
          ev[1] = 1'b1;
          if (m_cnt >= 1) ev[2] = 1'b1;
          m_cnt++;
        end
      end
      if (esf) begin
        if (isf && fn == 1) begin
          if (m_run) begin m_ref = crc_of_queue(); m_refv = 1'b1; end
          m_q.delete();
          m_run = 1'b1;
        end
        if (m_run) m_q.push_back(isf ? 1'b1 : d);
        if (isf && fn % 4 == 2) begin
          m_rx = {m_rx[4:0], d};
          if (fn == 22 && m_refv && m_rx != m_ref) ev[3] = 1'b1;
        end
      end else begin
        m_run = 1'b0; m_refv = 1'b0; m_q.delete();
      end
    end
    if (wr && a == 2'd0) m_st = m_st & ~wd[3:0];
    if (wr && a == 2'd1) m_mask = wd[3:0];
    m_st = m_st | ev;
  endtask

  task automatic chk(input bit ok, input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s%s act=%0h exp=%0h", rq, tag, act, exp);
    end
  endtask

  task automatic compare_all();
    if (reg_addr == 2'd0) begin
      chk(reg_rdata[0] == m_st[0], "R7 mfb", {7'd0, reg_rdata[0]}, {7'd0, m_st[0]});
      chk(reg_rdata[1] == m_st[1], fmt_esf ? "R3 ferr" : "R1 ferr", {7'd0, reg_rdata[1]}, {7'd0, m_st[1]});
      chk(reg_rdata[2] == m_st[2], fmt_esf ? "R4 sev" : "R2 sev", {7'd0, reg_rdata[2]}, {7'd0, m_st[2]});
      chk(reg_rdata[3] == m_st[3], "R5 crc", {7'd0, reg_rdata[3]}, {7'd0, m_st[3]});
      chk(reg_rdata[7:4] == 4'h0, "R9 upper", reg_rdata, {4'h0, m_st});
    end else if (reg_addr == 2'd1) begin
      chk(reg_rdata == {4'h0, m_mask}, "R9 mask", reg_rdata, {4'h0, m_mask});
    end else begin
      chk(reg_rdata == 8'h00, "R9 unmapped", reg_rdata, 8'h00);
    end
    chk(irq == |(m_st & m_mask), "R11 irq", {7'd0, irq}, {7'd0, |(m_st & m_mask)});
  endtask

  task automatic tick(input bit vld, input bit isf, input bit d, input bit wr,
                      input logic [1:0] a, input logic [7:0] wd);
    bit_vld = vld; fbit_stb = isf; bit_data = d;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    model_step(vld, isf, d, int'(frame_num), fmt_esf, in_sync, wr, a, wd);
    @(posedge clk);
    @(negedge clk);
    compare_all();
    reg_wr = 1'b0;
  endtask

  task automatic send_frame(input int fn, input bit flip, input bit clr);
    bit f;
    frame_num = 5'(fn);
    if (fmt_esf) begin
      if (fn % 4 == 0)      f = (fn == 12 || fn == 20 || fn == 24);
      else if (fn % 4 == 2) f = (m_refv && in_sync) ? m_ref[5 - (fn - 2) / 4] : rnd();
      else                  f = rnd();
    end else begin
      if (fn % 2 == 1) f = (fn % 4 == 1);
      else             f = (fn == 6 || fn == 8 || fn == 10);
    end
    tick(1'b1, 1'b1, f ^ flip, clr, 2'd0, clr ? 8'h0F : 8'h00);
    for (int i = 0; i < 192; i++) tick(1'b1, 1'b0, rnd(), 1'b0, 2'd0, 8'h00);
  endtask

  task automatic send_mf(input int unsigned flips, input int unsigned nosync, input int unsigned clrs);
    int n;
    n = fmt_esf ? 24 : 12;
    for (int fn = 1; fn <= n; fn++) begin
      in_sync = !nosync[fn];
      send_frame(fn, flips[fn], clrs[fn]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_data = 1'b0; fbit_stb = 1'b0;
    frame_num = 5'd0; fmt_esf = 1'b0; in_sync = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state on the ports
    chk(reg_rdata == 8'h00, "R12 status", reg_rdata, 8'h00);
    chk(irq == 1'b0, "R12 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    tag = " R12";
    tick(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
    tag = "";
    tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h0E);

    // superframe mode
    fmt_esf = 1'b0;
    send_mf(0, 0, 0);
    send_mf((1 << 3) | (1 << 4), 0, 1 << 1);   // R1: Ft error, Fs ignored
    send_mf((1 << 3) | (1 << 5), 0, 1 << 1);   // R2: two in one window
    send_mf((1 << 5) | (1 << 9), 0, 1 << 1);   // R2: split across windows
    tag = " R10";
    send_mf(1 << 3, 0, (1 << 1) | (1 << 3));   // clear collides with event
    tag = " R8";
    send_mf((1 << 3) | (1 << 5), 1 << 4, 1 << 1);
    send_mf(32'h1FFE, 32'h1FFE, 1 << 1);

    // extended superframe mode
    in_sync = 1'b0;
    tick(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    fmt_esf = 1'b1;
    tag = " R6";
    send_mf(0, 0, 1 << 1);
    tag = "";
    send_mf(0, 0, 1 << 1);                      // R5 clean compare
    send_mf(1 << 8, 0, 1 << 1);                 // R3 single error
    tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h08);
    send_mf((1 << 8) | (1 << 20) | (1 << 14), 0, 1 << 1);  // R4 + R5
    tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h0F);
    send_mf(1 << 24, 0, 1 << 1);
    tag = " R8";
    send_mf(1 << 4, (1 << 12) | (1 << 13), 1 << 1);
    tag = " R6";
    send_mf(0, 0, 1 << 1);
    tag = "";
    send_mf(0, 0, 1 << 1);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h0F);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    finish_run();
  end
endmodule